// File: doc/BRIEF.md
# Four-Channel Quadrature Position Counter with Index Capture

This block decodes four incremental encoders at once. Each channel takes an A phase, a B phase and an index (marker) input. It keeps a signed 32-bit position that moves by one on every valid edge of A or B. A, B and index first pass through a two-flop synchroniser and a glitch filter. The filter passes a level only after it has held for `FILT_N` consecutive samples.

The block is reached through a simple synchronous register bus. Word offsets 0 to 3 return the four positions. Offset 5 is a status/control word: a read returns the live index level of each channel and a sticky index flag per channel. A write to offset 5 clears any chosen subset of position counters and any chosen subset of index flags. Offset 7 returns a build-time version constant. Offsets 4 and 6 read as zero. Read data is registered, so it appears one cycle after the address.

Each channel's decoder is a four-state machine whose state is the last accepted phase pair {A,B}. The states are PH_00, PH_10, PH_11 and PH_01. The transitions are as follows:
- The forward ring PH_00→PH_10→PH_11→PH_01→PH_00 is an up step.
- The reverse ring PH_00→PH_01→PH_11→PH_10→PH_00 is a down step.
- Staying in the same state is no step.
- A jump to the diagonally opposite state is an illegal step. It produces no count, and the machine adopts the new phase.

Top module: `quad_encoder_bank`

## Requirements
- R1: After reset, every position reads 0, every index flag reads 0, and `bus_rdata` is 0.
- R2: When A leads B, taking {A,B} through 00→10→11→01→00, the channel's position rises by one on each transition.
- R3: When B leads A, taking {A,B} through 00→01→11→10→00, the position falls by one on each transition.
- R4: A transition in which A and B change in the same filtered sample leaves the position unchanged. Later steps are decoded from the new phase.
- R5: A level on A, B or index that lasts fewer than `FILT_N` (default 3) clock cycles after synchronisation has no effect.
- R6: Writing offset 5 with bit n of bits 3:0 set clears channel n's position to 0 on the next cycle. Channels whose bit is 0 keep their values. A clear takes priority over a count step in the same cycle.
- R7: The position wraps modulo 2^32 in two's complement: one down step from 0 gives 32'hFFFF_FFFF.
- R8: Status bits 23:20 give the filtered index level of channels 0 to 3. All other status bits that are not index flags read 0.
- R9: Status bits 27:24 are sticky flags, one per channel. Each is set by a rising edge of that channel's filtered index and stays set after the index falls.
- R10: Writing 1 to status bit 24+n clears flag n. If a rising index edge on channel n lands in the same cycle, the flag stays set.
- R11: Reading offset k, for k from 0 to 3, returns position k. Offset 5 returns status, offset 7 returns `VERSION`, and offsets 4 and 6 return 0. Data appears on `bus_rdata` one clock after the address is presented.
- R12: Channels are independent: stimulus or a clear on one channel changes no other channel's position or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 4 | A phase, one bit per channel |
| enc_b | input | 4 | B phase, one bit per channel |
| enc_idx | input | 4 | Index marker, one bit per channel |
| bus_addr | input | 3 | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench drives random mixes of forward, reverse, held and illegal phase moves on all four channels at once, and compares every position against a bench model. A decoder that counted diagonal jumps, or that lost its phase after one, would drift from the model within a few steps. Directed cases cover the following:
- A down step from zero, which a saturating or unsigned counter would get wrong.
- One- and two-cycle glitches, which an unfiltered input would count.
- A partial clear mask, which a counter wired to the wrong bit would misapply.
- A flag clear that lands in the same cycle as a new index edge, which a clear-first priority would lose.

// File: rtl/qe_pkg.sv
package qe_pkg;

    // Decoder state: last accepted {A,B} phase pair
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } phase_t;

    // Register bank word offsets
    localparam int unsigned OFF_GAP0 = 4;
    localparam int unsigned OFF_STAT = 5;
    localparam int unsigned OFF_GAP1 = 6;
    localparam int unsigned OFF_VER  = 7;

    // Status / control field positions
    localparam int unsigned CLR_LSB   = 0;
    localparam int unsigned LIVE_LSB  = 20;
    localparam int unsigned LATCH_LSB = 24;

endpackage

// File: rtl/qe_sync_filter.sv
module qe_sync_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_N      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned HIST_W = FILT_N - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;
    logic [FILT_N-1:0]      window;
    logic                   filt_q;

    assign window = {hist_q, sync_q[SYNC_STAGES-1]};
    assign dout   = filt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= window[HIST_W-1:0];
            if (&window)
                filt_q <= 1'b1;
            else if (~|window)
                filt_q <= 1'b0;
        end
    end

    // R5
    filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> $past(&window));

    // R5
    filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_q) |-> $past(~|window));

endmodule

// File: rtl/qe_phase_fsm.sv
module qe_phase_fsm
    import qe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_f,
    input  logic b_f,
    output logic step_up,
    output logic step_dn
);
    phase_t state_q;
    phase_t cur;
    logic   bad;

    assign cur = phase_t'({a_f, b_f});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_00;
        else
            state_q <= cur;
    end

    // Step outputs
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        bad     = 1'b0;
        unique case (state_q)
            PH_00: begin
                step_up = (cur == PH_10);
                step_dn = (cur == PH_01);
                bad     = (cur == PH_11);
            end
            PH_10: begin
                step_up = (cur == PH_11);
                step_dn = (cur == PH_00);
                bad     = (cur == PH_01);
            end
            PH_11: begin
                step_up = (cur == PH_01);
                step_dn = (cur == PH_10);
                bad     = (cur == PH_00);
            end
            PH_01: begin
                step_up = (cur == PH_00);
                step_dn = (cur == PH_11);
                bad     = (cur == PH_10);
            end
        endcase
    end

    // R2
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R4
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (!step_up && !step_dn && $countones(state_q ^ cur) == 2));

    // R2
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> $countones(state_q ^ cur) == 1);

endmodule

// File: rtl/qe_channel.sv
module qe_channel #(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_N      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_idx,
    input  logic             cnt_clr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             idx_live,
    output logic             idx_flag
);
    logic a_f, b_f, idx_f;
    logic up, dn;
    logic idx_prev_q;
    logic idx_rise;
    logic [CNT_W-1:0] cnt_q;
    logic flag_q;

    qe_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)) u_filt_a (
        .clk(clk), .rst_n(rst_n), .din(pin_a), .dout(a_f));
    qe_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)) u_filt_b (
        .clk(clk), .rst_n(rst_n), .din(pin_b), .dout(b_f));
    qe_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)) u_filt_idx (
        .clk(clk), .rst_n(rst_n), .din(pin_idx), .dout(idx_f));

    qe_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .a_f(a_f), .b_f(b_f),
        .step_up(up), .step_dn(dn));

    assign idx_rise = idx_f & ~idx_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            idx_prev_q <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            idx_prev_q <= idx_f;
            if (cnt_clr)
                cnt_q <= '0;
            else if (up)
                cnt_q <= cnt_q + 1'b1;
            else if (dn)
                cnt_q <= cnt_q - 1'b1;
            if (idx_rise)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign count    = cnt_q;
    assign idx_live = idx_f;
    assign idx_flag = flag_q;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));

    // R2
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !cnt_clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !cnt_clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && !cnt_clr) |=> $stable(cnt_q));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rise |=> flag_q);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !idx_rise) |=> !flag_q);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/quad_encoder_bank.sv
module quad_encoder_bank
    import qe_pkg::*;
#(
    parameter int unsigned  NUM_CH      = 4,
    parameter int unsigned  CNT_W       = 32,
    parameter int unsigned  DATA_W      = 32,
    parameter int unsigned  ADDR_W      = 3,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter int unsigned  FILT_N      = 3,
    parameter logic [31:0]  VERSION     = 32'h0001_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] enc_a,
    input  logic [NUM_CH-1:0] enc_b,
    input  logic [NUM_CH-1:0] enc_idx,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CNT_W-1:0]  cnt_arr [NUM_CH];
    logic [NUM_CH-1:0] live_vec;
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] fclr_vec;
    logic              wr_stat;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    assign wr_stat  = bus_wr && (int'(bus_addr) == OFF_STAT);
    assign clr_vec  = wr_stat ? bus_wdata[CLR_LSB +: NUM_CH] : '0;
    assign fclr_vec = wr_stat ? bus_wdata[LATCH_LSB +: NUM_CH] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qe_channel #(
            .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_a    (enc_a[g]),
            .pin_b    (enc_b[g]),
            .pin_idx  (enc_idx[g]),
            .cnt_clr  (clr_vec[g]),
            .flag_clr (fclr_vec[g]),
            .count    (cnt_arr[g]),
            .idx_live (live_vec[g]),
            .idx_flag (flag_vec[g])
        );
    end

    always_comb begin
        status_word = '0;
        status_word[LIVE_LSB +: NUM_CH]  = live_vec;
        status_word[LATCH_LSB +: NUM_CH] = flag_vec;
    end

    always_comb begin
        rd_next = '0;
        if (int'(bus_addr) < NUM_CH)
            rd_next = DATA_W'(cnt_arr[bus_addr[CH_W-1:0]]);
        else if (int'(bus_addr) == OFF_STAT)
            rd_next = status_word;
        else if (int'(bus_addr) == OFF_VER)
            rd_next = DATA_W'(VERSION);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;

    // R11
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == OFF_GAP0 || int'(bus_addr) == OFF_GAP1) |=> (bus_rdata == '0));

    // R11
    version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == OFF_VER) |=> (bus_rdata == DATA_W'(VERSION)));

    // R8
    status_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == OFF_STAT) |=>
            ($countones(bus_rdata) == $countones($past(live_vec)) + $countones($past(flag_vec))));

endmodule

// File: tb/test_quad_encoder_bank.sv
`timescale 1ns/1ps
module test_quad_encoder_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  enc_a = '0, enc_b = '0, enc_idx = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] exp_cnt [4];
    logic [31:0] rd;

    localparam logic [31:0] VER = 32'h0001_0400;

    always #5 clk = ~clk;

    quad_encoder_bank i_quad_encoder_bank (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic rd_word(input int off, output logic [31:0] v);
        @(negedge clk) bus_addr = 3'(off);
        @(negedge clk) v = bus_rdata;
    endtask

    task automatic wr_stat(input logic [31:0] v);
        @(negedge clk) begin bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = v; end
        @(negedge clk) bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [1:0] fwd(input logic [1:0] p);
        case (p)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] p);
        case (p)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // Move one channel's phase; mode 0 fwd, 1 rev, 2 hold, 3 illegal
    task automatic move(input int ch, input int mode);
        logic [1:0] p, n;
        p = {enc_a[ch], enc_b[ch]};
        case (mode)
            0: begin n = fwd(p); exp_cnt[ch] = exp_cnt[ch] + 1; end
            1: begin n = rev(p); exp_cnt[ch] = exp_cnt[ch] - 1; end
            2: n = p;
            default: n = ~p;
        endcase
        enc_a[ch] = n[1];
        enc_b[ch] = n[0];
    endtask

    task automatic check_counts(input string req);
        for (int c = 0; c < 4; c++) begin
            rd_word(c, rd);
            check(req, rd, exp_cnt[c]);
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) exp_cnt[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check_counts("R1 counts");
        rd_word(5, rd);
        check("R1 status", rd, 32'h0);

        // R11 map
        rd_word(7, rd); check("R11 version", rd, VER);
        rd_word(4, rd); check("R11 gap4", rd, 32'h0);
        rd_word(6, rd); check("R11 gap6", rd, 32'h0);

        // R2 forward full cycle on ch0
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) move(0, 0);
            settle();
        end
        rd_word(0, rd); check("R2 forward", rd, 32'd4);

        // R3 reverse on ch1 and R12 other channels still zero
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) move(1, 1);
            settle();
        end
        check_counts("R3/R12 reverse");

        // R4 illegal jump on ch2 then decode from new phase
        @(negedge clk) move(2, 3);
        settle();
        rd_word(2, rd); check("R4 illegal", rd, exp_cnt[2]);
        @(negedge clk) move(2, 0);
        settle();
        rd_word(2, rd); check("R4 resume", rd, exp_cnt[2]);

        // R5 glitches of one and two cycles on ch3 A
        for (int w = 1; w <= 2; w++) begin
            @(negedge clk) enc_a[3] = ~enc_a[3];
            repeat (w) @(negedge clk);
            enc_a[3] = ~enc_a[3];
            settle();
            rd_word(3, rd); check("R5 glitch", rd, exp_cnt[3]);
        end

        // R7 wrap below zero on ch3
        wr_stat(32'h0000_0008); exp_cnt[3] = '0;
        @(negedge clk) move(3, 1);
        settle();
        rd_word(3, rd); check("R7 wrap", rd, 32'hFFFF_FFFF);

        // Random mix on all channels
        for (int it = 0; it < 60; it++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) move(c, int'($urandom % 8) / 2);
            settle();
            if (it % 10 == 9) check_counts("R2/R3/R4 random");
        end

        // R6 partial clear mask 1010, R12 others keep
        wr_stat(32'h0000_000A);
        exp_cnt[1] = '0; exp_cnt[3] = '0;
        check_counts("R6/R12 clear");

        // R8/R9 live index and sticky flags
        @(negedge clk) enc_idx = 4'b0101;
        settle();
        rd_word(5, rd); check("R8/R9 index high", rd, 32'h0550_0000);
        @(negedge clk) enc_idx = 4'b0000;
        settle();
        rd_word(5, rd); check("R9 sticky", rd, 32'h0500_0000);

        // R10 write-one-clear of flag 0 only
        wr_stat(32'h0100_0000);
        rd_word(5, rd); check("R10 clear", rd, 32'h0400_0000);

        // R10 set wins: clear lands on the rise cycle of ch3 index
        @(negedge clk) enc_idx[3] = 1'b1;
        repeat (5) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0800_0000;
        @(negedge clk) bus_wr = 1'b0;
        settle();
        rd_word(5, rd); check("R10 set wins", rd, 32'h0C80_0000);

        // R5 index glitch on ch1 sets nothing
        wr_stat(32'h0C00_0000);
        @(negedge clk) enc_idx[1] = 1'b1;
        @(negedge clk) enc_idx[1] = 1'b0;
        settle();
        rd_word(5, rd); check("R5 index glitch", rd, 32'h0080_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule